// File: doc/BRIEF.md
# Modem Handshake and Flow-Control Unit

This block sits beside the transmitter and receiver of one 16550-style UART channel and owns the modem side of it. It holds a byte-wide modem control register that sets the active-low DTR# and RTS# pins. It also holds a line control byte, whose top bit chooses the divisor latch, and a feature control byte, which can invert the infrared receive input. Software writes and reads these three bytes through a plain register port.

When automatic hardware flow control is switched on from outside, the unit watches the receive FIFO level. It takes back its request when the level reaches an upper threshold and raises it again once the level drops to a lower threshold. A control bit picks whether that request goes out on RTS# or on DTR#. The same bit picks whether CTS# or DSR# pauses the transmitter. For software flow control the unit tracks an Xoff-halted state. In Xon-any mode, any received character ends that state. Otherwise only a matching Xon does.

The unit also routes the serial path. In internal loopback it folds the transmit data and the four control outputs back onto the receive data and modem status, and it parks the external pins. In infrared mode it moves transmit and receive onto the encoder/decoder path.

Top module: `mdm_flow_unit`

## Requirements
- R1: After reset, the modem, line and feature bytes all read 0, DTR# and RTS# are high, the divisor-latch select is 0, and both transmit-stop outputs are 0.
- R2: Outside loopback, and unless DTR# carries the auto-flow request, DTR# is the inverse of modem bit 0.
- R3: Outside loopback, and unless RTS# carries the auto-flow request, RTS# is the inverse of modem bit 1.
- R4: With auto flow on and modem bit 2 = 0, RTS# goes high one clock after the FIFO level is at or above the upper threshold. It goes low one clock after the level is at or below the lower threshold, and it holds its value between the two. DTR# still follows bit 0.
- R5: With auto flow on and modem bit 2 = 1, the request moves to DTR# with the same thresholds, and RTS# follows bit 1.
- R6: The hardware stall output is high while auto flow is on and the selected input is high: CTS# when bit 2 = 0, or DSR# when bit 2 = 1.
- R7: With auto flow off, bit 2 has no effect on the pins and the hardware stall output is 0.
- R8: When modem bit 4 is set (loopback), receive data equals transmit data and the status outputs are taken from modem bits. Status bit 0 (CTS) takes bit 1, status bit 1 (DSR) takes bit 0, status bit 2 (RI) takes bit 2, and status bit 3 (CD) takes bit 3. DTR# and RTS# are held high and the external modem inputs are ignored. Outside loopback each status bit is the inverse of its pin.
- R9: With software flow on and modem bit 5 set, a received-character strobe clears the halted state one clock later.
- R10: With software flow on, an Xoff strobe sets the halted state one clock later and wins over any Xon or character strobe in the same clock. With bit 5 clear, only an Xon clears the state. With software flow off, the state is 0.
- R11: Infrared mode is on when modem bit 6 or the external infrared-enable input is set. In that mode the serial output takes the encoder output, receive data takes the decoder output, and the decoder input is the line input, inverted when feature bit 4 is set. The serial output idles at 1 in loopback without infrared and at 0 in loopback with infrared.
- R12: The divisor-latch select output equals line byte bit 7.
- R13: Address 0 holds the modem byte, address 1 the line byte and address 2 the feature byte, each read back as written from the clock after the write. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr |
| autoHwEn | input | 1 | Automatic hardware flow enable |
| swFlowEn | input | 1 | Software (Xon/Xoff) flow enable |
| irPinEn | input | 1 | External infrared-enable input |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| hiThresh | input | LVL_W | Upper request threshold |
| loThresh | input | LVL_W | Lower request threshold |
| rxXonHit | input | 1 | Xon character received |
| rxXoffHit | input | 1 | Xoff character received |
| rxCharStrobe | input | 1 | Any character received |
| txData | input | 1 | Serial data from transmit shifter |
| rxPin | input | 1 | Serial line input |
| irEncOut | input | 1 | Infrared encoder output |
| irDecOut | input | 1 | Infrared decoder output |
| ctsN | input | 1 | CTS# pin |
| dsrN | input | 1 | DSR# pin |
| riN | input | 1 | RI# pin |
| cdN | input | 1 | CD# pin |
| txPin | output | 1 | Serial line output |
| rxData | output | 1 | Serial data to receive shifter |
| irDecIn | output | 1 | Infrared decoder input |
| dtrN | output | 1 | DTR# pin |
| rtsN | output | 1 | RTS# pin |
| modemSt | output | 4 | Active-high status {CD,RI,DSR,CTS} |
| divLatchSel | output | 1 | Divisor-latch select |
| txHwStall | output | 1 | Hardware flow stall |
| txSwHalt | output | 1 | Xoff-halted state |

## Verification
The FIFO level is swept up through the upper threshold and back down through the lower one, first with RTS# and then with DTR# carrying the request. Readings between the thresholds separate real hysteresis from a plain compare. The modem inputs and serial data are random on every clock, with loopback both on and off, so a swapped status mapping or a leak of external pins in loopback shows up. Xoff, Xon and character strobes are sent alone and in pairs with Xon-any on and off, which tells apart the clear sources and the priority. The infrared path is run with and without the inversion and with either enable source.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic [1:0] {
    ADDR_MODEM = 2'd0,
    ADDR_LINE  = 2'd1,
    ADDR_FEAT  = 2'd2,
    ADDR_NONE  = 2'd3
  } regAddr_e;

  localparam int BIT_DTR     = 0;
  localparam int BIT_RTS     = 1;
  localparam int BIT_FLOWSEL = 2;
  localparam int BIT_OP2     = 3;
  localparam int BIT_LOOP    = 4;
  localparam int BIT_XONANY  = 5;
  localparam int BIT_IR      = 6;
  localparam int BIT_DLSEL   = 7;
  localparam int BIT_RXINV   = 4;

  // control strobes from the register/flow side to the path side
  typedef struct packed {
    logic loopEn;
    logic irEn;
    logic rxInv;
    logic dtrAct;
    logic rtsAct;
    logic dtrBit;
    logic rtsBit;
    logic op1Bit;
    logic op2Bit;
  } ctlBundle_t;
endpackage

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             autoHwEn,
  input  logic             swFlowEn,
  input  logic             irPinEn,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] hiThresh,
  input  logic [LVL_W-1:0] loThresh,
  input  logic             rxXonHit,
  input  logic             rxXoffHit,
  input  logic             rxCharStrobe,
  input  logic             ctsSt,
  input  logic             dsrSt,
  output ctlBundle_t       bundle,
  output logic [REG_W-1:0] modeBits,
  output logic             divLatchSel,
  output logic             txHwStall,
  output logic             txSwHalt
);
  logic [REG_W-1:0] modeReg, lineReg, featReg;
  logic             reqOn;
  logic             haltReg;
  logic             useDtr;
  regAddr_e         addrSel;

  assign addrSel = regAddr_e'(regAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      lineReg <= '0;
      featReg <= '0;
    end else if (regWrEn) begin
      case (addrSel)
        ADDR_MODEM: modeReg <= regWrData;
        ADDR_LINE:  lineReg <= regWrData;
        ADDR_FEAT:  featReg <= regWrData;
        default:    ;
      endcase
    end
  end

  // request hysteresis on the receive FIFO level
  always_ff @(posedge clk) begin
    if (!rstN || !autoHwEn) begin
      reqOn <= 1'b1;
    end else if (rxLevel >= hiThresh) begin
      reqOn <= 1'b0;
    end else if (rxLevel <= loThresh) begin
      reqOn <= 1'b1;
    end
  end

  // Xoff-halted state, Xoff has priority
  always_ff @(posedge clk) begin
    if (!rstN || !swFlowEn) begin
      haltReg <= 1'b0;
    end else if (rxXoffHit) begin
      haltReg <= 1'b1;
    end else if (rxXonHit || (modeReg[BIT_XONANY] && rxCharStrobe)) begin
      haltReg <= 1'b0;
    end
  end

  always_comb begin
    case (addrSel)
      ADDR_MODEM: regRdData = modeReg;
      ADDR_LINE:  regRdData = lineReg;
      ADDR_FEAT:  regRdData = featReg;
      default:    regRdData = '0;
    endcase
  end

  assign useDtr = modeReg[BIT_FLOWSEL];

  always_comb begin
    bundle.loopEn = modeReg[BIT_LOOP];
    bundle.irEn   = modeReg[BIT_IR] | irPinEn;
    bundle.rxInv  = featReg[BIT_RXINV];
    bundle.dtrBit = modeReg[BIT_DTR];
    bundle.rtsBit = modeReg[BIT_RTS];
    bundle.op1Bit = modeReg[BIT_FLOWSEL];
    bundle.op2Bit = modeReg[BIT_OP2];
    bundle.dtrAct = (autoHwEn && useDtr)  ? reqOn : modeReg[BIT_DTR];
    bundle.rtsAct = (autoHwEn && !useDtr) ? reqOn : modeReg[BIT_RTS];
  end

  assign txHwStall   = autoHwEn & (useDtr ? ~dsrSt : ~ctsSt);
  assign txSwHalt    = haltReg;
  assign divLatchSel = lineReg[BIT_DLSEL];
  assign modeBits    = modeReg;
endmodule

// File: rtl/mdm_path.sv
module mdm_path
  import mdm_pkg::*;
#(
  parameter int ST_N = 4
) (
  input  ctlBundle_t      bundle,
  input  logic            txData,
  input  logic            rxPin,
  input  logic            irEncOut,
  input  logic            irDecOut,
  input  logic [ST_N-1:0] stPinN,
  output logic [ST_N-1:0] stOut,
  output logic            txPin,
  output logic            rxData,
  output logic            irDecIn,
  output logic            dtrN,
  output logic            rtsN
);
  logic [ST_N-1:0] loopSrc;

  // status order: 0 CTS, 1 DSR, 2 RI, 3 CD
  assign loopSrc = {bundle.op2Bit, bundle.op1Bit, bundle.dtrBit, bundle.rtsBit};

  for (genvar i = 0; i < ST_N; i++) begin : g_status
    assign stOut[i] = bundle.loopEn ? loopSrc[i] : ~stPinN[i];
  end

  always_comb begin
    if (bundle.loopEn) begin
      txPin  = ~bundle.irEn;
      rxData = txData;
    end else if (bundle.irEn) begin
      txPin  = irEncOut;
      rxData = irDecOut;
    end else begin
      txPin  = txData;
      rxData = rxPin;
    end
  end

  assign irDecIn = rxPin ^ bundle.rxInv;
  assign dtrN    = bundle.loopEn | ~bundle.dtrAct;
  assign rtsN    = bundle.loopEn | ~bundle.rtsAct;
endmodule

// File: rtl/mdm_flow_unit.sv
module mdm_flow_unit
  import mdm_pkg::*;
#(
  parameter int LVL_W = 6,
  parameter int REG_W = 8,
  localparam int ST_N = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             autoHwEn,
  input  logic             swFlowEn,
  input  logic             irPinEn,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] hiThresh,
  input  logic [LVL_W-1:0] loThresh,
  input  logic             rxXonHit,
  input  logic             rxXoffHit,
  input  logic             rxCharStrobe,
  input  logic             txData,
  input  logic             rxPin,
  input  logic             irEncOut,
  input  logic             irDecOut,
  input  logic             ctsN,
  input  logic             dsrN,
  input  logic             riN,
  input  logic             cdN,
  output logic             txPin,
  output logic             rxData,
  output logic             irDecIn,
  output logic             dtrN,
  output logic             rtsN,
  output logic [ST_N-1:0]  modemSt,
  output logic             divLatchSel,
  output logic             txHwStall,
  output logic             txSwHalt
);
  ctlBundle_t       bundle;
  logic [REG_W-1:0] modeBits;

  mdm_ctrl #(.LVL_W(LVL_W), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .autoHwEn(autoHwEn), .swFlowEn(swFlowEn), .irPinEn(irPinEn),
    .rxLevel(rxLevel), .hiThresh(hiThresh), .loThresh(loThresh),
    .rxXonHit(rxXonHit), .rxXoffHit(rxXoffHit), .rxCharStrobe(rxCharStrobe),
    .ctsSt(modemSt[0]), .dsrSt(modemSt[1]),
    .bundle(bundle), .modeBits(modeBits), .divLatchSel(divLatchSel),
    .txHwStall(txHwStall), .txSwHalt(txSwHalt)
  );

  mdm_path #(.ST_N(ST_N)) u_path (
    .bundle(bundle), .txData(txData), .rxPin(rxPin),
    .irEncOut(irEncOut), .irDecOut(irDecOut),
    .stPinN({cdN, riN, dsrN, ctsN}), .stOut(modemSt),
    .txPin(txPin), .rxData(rxData), .irDecIn(irDecIn),
    .dtrN(dtrN), .rtsN(rtsN)
  );
endmodule

// File: rtl/mdm_flow_chk.sv
module mdm_flow_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] modeBits,
  input logic             autoHwEn,
  input logic             swFlowEn,
  input logic             rxXonHit,
  input logic             rxXoffHit,
  input logic             rxCharStrobe,
  input logic             txData,
  input logic             rxData,
  input logic             dtrN,
  input logic             rtsN,
  input logic             txHwStall,
  input logic             txSwHalt
);
  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    modeBits[4] |-> (dtrN && rtsN)); // R8
  AST_LOOP_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    modeBits[4] |-> (rxData == txData)); // R8
  AST_NO_STALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !autoHwEn |-> !txHwStall); // R7
  AST_XOFF_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (swFlowEn && rxXoffHit) |=> txSwHalt); // R10
  AST_XON_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (swFlowEn && rxXonHit && !rxXoffHit) |=> !txSwHalt); // R10
  AST_XONANY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (swFlowEn && modeBits[5] && rxCharStrobe && !rxXoffHit) |=> !txSwHalt); // R9
endmodule

bind mdm_flow_unit mdm_flow_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeBits(modeBits),
  .autoHwEn(autoHwEn), .swFlowEn(swFlowEn),
  .rxXonHit(rxXonHit), .rxXoffHit(rxXoffHit), .rxCharStrobe(rxCharStrobe),
  .txData(txData), .rxData(rxData), .dtrN(dtrN), .rtsN(rtsN),
  .txHwStall(txHwStall), .txSwHalt(txSwHalt)
);

// File: tb/test_mdm_flow_unit.sv
`timescale 1ns/1ps
module test_mdm_flow_unit;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic autoHwEn = 1'b0, swFlowEn = 1'b0, irPinEn = 1'b0;
  logic [LW-1:0] rxLevel = '0, hiThresh = 6'd12, loThresh = 6'd4;
  logic rxXonHit = 1'b0, rxXoffHit = 1'b0, rxCharStrobe = 1'b0;
  logic txData = 1'b0, rxPin = 1'b0, irEncOut = 1'b0, irDecOut = 1'b0;
  logic ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, cdN = 1'b1;
  logic txPin, rxData, irDecIn, dtrN, rtsN, divLatchSel, txHwStall, txSwHalt;
  logic [3:0] modemSt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] mMode = 0, mLine = 0, mFeat = 0;
  logic mReq = 1'b1, mHalt = 1'b0;

  always #2 clk = ~clk;

  mdm_flow_unit #(.LVL_W(LW)) i_mdm_flow_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .autoHwEn(autoHwEn), .swFlowEn(swFlowEn), .irPinEn(irPinEn),
    .rxLevel(rxLevel), .hiThresh(hiThresh), .loThresh(loThresh),
    .rxXonHit(rxXonHit), .rxXoffHit(rxXoffHit), .rxCharStrobe(rxCharStrobe),
    .txData(txData), .rxPin(rxPin), .irEncOut(irEncOut), .irDecOut(irDecOut),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .cdN(cdN),
    .txPin(txPin), .rxData(rxData), .irDecIn(irDecIn), .dtrN(dtrN), .rtsN(rtsN),
    .modemSt(modemSt), .divLatchSel(divLatchSel),
    .txHwStall(txHwStall), .txSwHalt(txSwHalt)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // random background on the free-running pins
  always @(negedge clk) begin
    txData   <= 1'($urandom);
    rxPin    <= 1'($urandom);
    irEncOut <= 1'($urandom);
    irDecOut <= 1'($urandom);
    ctsN     <= 1'($urandom);
    dsrN     <= 1'($urandom);
    riN      <= 1'($urandom);
    cdN      <= 1'($urandom);
  end

  // behavioural model, compared every clock
  always @(posedge clk) begin
    logic loop, ir, eDtr, eRts, eCts, eDsr;
    logic [3:0] eSt;
    int eRd;
    if (!rstN) begin
      mMode = 0; mLine = 0; mFeat = 0; mReq = 1; mHalt = 0;
    end else begin
      if (!autoHwEn) mReq = 1;
      else if (rxLevel >= hiThresh) mReq = 0;
      else if (rxLevel <= loThresh) mReq = 1;
      if (!swFlowEn) mHalt = 0;
      else if (rxXoffHit) mHalt = 1;
      else if (rxXonHit || (mMode[5] && rxCharStrobe)) mHalt = 0;
      if (regWrEn) begin
        if (regAddr == 0) mMode = regWrData;
        else if (regAddr == 1) mLine = regWrData;
        else if (regAddr == 2) mFeat = regWrData;
      end
    end
    #1;
    if (rstN) begin
      loop = mMode[4];
      ir = mMode[6] | irPinEn;
      eDtr = (autoHwEn && mMode[2]) ? ~mReq : ~mMode[0];
      eRts = (autoHwEn && !mMode[2]) ? ~mReq : ~mMode[1];
      if (loop) begin eDtr = 1; eRts = 1; end
      eSt = loop ? {mMode[3], mMode[2], mMode[0], mMode[1]} : ~{cdN, riN, dsrN, ctsN};
      eCts = eSt[0]; eDsr = eSt[1];
      eRd = (regAddr == 0) ? mMode : (regAddr == 1) ? mLine : (regAddr == 2) ? mFeat : 0;
      chk("R2", "dtrN", dtrN, eDtr);
      chk("R3", "rtsN", rtsN, eRts);
      chk("R8", "modemSt", modemSt, eSt);
      chk("R8", "rxData", rxData, loop ? txData : (ir ? irDecOut : rxPin));
      chk("R11", "txPin", txPin, loop ? !ir : (ir ? irEncOut : txData));
      chk("R11", "irDecIn", irDecIn, rxPin ^ mFeat[4]);
      chk("R6", "txHwStall", txHwStall, autoHwEn && (mMode[2] ? !eDsr : !eCts));
      chk("R10", "txSwHalt", txSwHalt, mHalt);
      chk("R12", "divLatchSel", divLatchSel, mLine[7]);
      chk("R13", "regRdData", regRdData, eRd);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWrEn = 1; regAddr = 2'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    rstN = 1;
    #1;
    // R1 reset state, before any write
    chk("R1", "dtrN", dtrN, 1);
    chk("R1", "rtsN", rtsN, 1);
    chk("R1", "divLatchSel", divLatchSel, 0);
    chk("R1", "txHwStall", txHwStall, 0);
    chk("R1", "txSwHalt", txSwHalt, 0);
    for (int a = 0; a < 3; a++) begin
      regAddr = 2'(a); #0.1;
      chk("R1", "regRdData", regRdData, 0);
    end

    // R2 / R3 pin polarity
    wr(0, 8'h01); #1; chk("R2", "dtrN low", dtrN, 0); chk("R3", "rtsN high", rtsN, 1);
    wr(0, 8'h02); #1; chk("R2", "dtrN high", dtrN, 1); chk("R3", "rtsN low", rtsN, 0);

    // R4 RTS request hysteresis
    wr(0, 8'h01);
    autoHwEn = 1;
    tick(2);
    for (int l = 0; l <= 14; l++) begin rxLevel = 6'(l); tick(1); end
    #1; chk("R4", "rtsN high above hi", rtsN, 1); chk("R4", "dtrN follows bit0", dtrN, 0);
    rxLevel = 6'd8; tick(2); #1; chk("R4", "rtsN held between", rtsN, 1);
    rxLevel = 6'd4; tick(1); #1; chk("R4", "rtsN low at lo", rtsN, 0);
    rxLevel = 6'd8; tick(2); #1; chk("R4", "rtsN held low between", rtsN, 0);
    rxLevel = 6'd12; tick(1); #1; chk("R4", "rtsN high at hi", rtsN, 1);

    // R5 DTR request
    wr(0, 8'h06); #1; chk("R5", "dtrN carries request", dtrN, 1); chk("R5", "rtsN follows bit1", rtsN, 0);
    for (int l = 12; l >= 0; l--) begin rxLevel = 6'(l); tick(1); end
    #1; chk("R5", "dtrN low after drain", dtrN, 0);
    tick(8);

    // R7 auto flow off: bit 2 no effect
    autoHwEn = 0; rxLevel = 6'd20;
    wr(0, 8'h04); tick(2); #1;
    chk("R7", "dtrN follows bit0", dtrN, 1); chk("R7", "rtsN follows bit1", rtsN, 1);
    chk("R7", "no stall", txHwStall, 0);
    rxLevel = 0;

    // R8 loopback with various control patterns
    wr(0, 8'h10); tick(6);
    wr(0, 8'h1f); tick(6);
    wr(0, 8'h15); autoHwEn = 1; tick(6);
    wr(0, 8'h1a); tick(6);
    autoHwEn = 0;
    wr(0, 8'h00); tick(6);

    // R10 / R9 software flow
    swFlowEn = 1;
    rxXoffHit = 1; tick(1); rxXoffHit = 0; #1; chk("R10", "halt on xoff", txSwHalt, 1);
    rxCharStrobe = 1; tick(1); rxCharStrobe = 0; #1; chk("R10", "char ignored w/o xon-any", txSwHalt, 1);
    rxXonHit = 1; tick(1); rxXonHit = 0; #1; chk("R10", "xon clears", txSwHalt, 0);
    wr(0, 8'h20);
    rxXoffHit = 1; tick(1); rxXoffHit = 0; #1; chk("R10", "halt again", txSwHalt, 1);
    rxCharStrobe = 1; tick(1); rxCharStrobe = 0; #1; chk("R9", "any char clears", txSwHalt, 0);
    rxXoffHit = 1; rxCharStrobe = 1; tick(1); rxXoffHit = 0; rxCharStrobe = 0; #1;
    chk("R10", "xoff wins over char", txSwHalt, 1);
    rxXoffHit = 1; rxXonHit = 1; tick(1); rxXoffHit = 0; rxXonHit = 0; #1;
    chk("R10", "xoff wins over xon", txSwHalt, 1);
    swFlowEn = 0; tick(1); #1; chk("R10", "cleared when off", txSwHalt, 0);

    // R11 infrared path
    wr(0, 8'h40); tick(5);
    wr(2, 8'h10); tick(5);
    wr(0, 8'h50); tick(4);
    wr(0, 8'h00); irPinEn = 1; tick(5);
    irPinEn = 0; wr(2, 8'h00); tick(3);

    // R12 / R13 line byte and unused address
    wr(1, 8'h80); #1; chk("R12", "divLatchSel set", divLatchSel, 1);
    wr(1, 8'h7f); #1; chk("R12", "divLatchSel clear", divLatchSel, 0);
    wr(3, 8'hff); #1; chk("R13", "addr3 reads 0", regRdData, 0);
    regAddr = 0; #0.1; chk("R13", "modem byte untouched", regRdData, 0);
    regAddr = 1; #0.1; chk("R13", "line byte untouched", regRdData, 8'h7f);
    tick(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule